// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Level Flags

This block is a single-clock queue of `DEPTH` words. Its read side can behave in one of two ways, and the choice is fixed while reset is held. In fall-through mode the oldest word is moved into the output register without being asked for, and `rd_avail` acts as an output-ready flag. In standard mode the output register changes only when a read is accepted, and `rd_avail` acts as a not-empty flag. On the write side, `wr_room` reports whether there is space left.

Each port has a qualifier pin (`wr_mbox`, `rd_mbox`). When that pin is high, the access is steered away from the queue and the queue ignores it. Two level flags, both active low, report "few words left" and "nearly full". Their thresholds come from two offset inputs that are captured during reset. A word held in the output register is not counted as stored. Its memory slot is freed as soon as the word leaves memory.

Internally, each side sees the other side's pointer through one register stage. This is the same latency that a synchronised two-clock build would have, so the flag timing is deterministic.

Top module: `dmf_fifo`

## Requirements
- R1: A read is accepted on a rising `clk` only when `rd_cs_n`=0, `rd_en`=1, `rd_mbox`=0 and `rd_avail`=1. Any other combination leaves `rd_data` and `rd_avail` unchanged.
- R2: A write is accepted on a rising `clk` only when `wr_en`=1, `wr_mbox`=0 and `wr_room`=1. A write that is not accepted stores nothing.
- R3: In fall-through mode, with `rd_avail`=0, a word written on edge k appears on `rd_data` after edge k+2. On that same edge `rd_avail` rises, and no read is needed.
- R4: In fall-through mode, while `rd_avail`=1, `rd_data` holds its value until a read is accepted. An accepted read loads the next stored word in write order, or drops `rd_avail` if memory is empty.
- R5: In standard mode, a word written on edge k into an empty queue raises `rd_avail` after edge k+2, while `rd_data` keeps its old value. An accepted read loads the oldest word into `rd_data` on that edge.
- R6: The output register is not counted. In fall-through mode the queue takes `DEPTH`+1 writes before `wr_room` falls, and a single word sitting in the output register leaves `rd_aempty_n`=0.
- R7: Let N be the number of words in memory. `rd_aempty_n`=0 when N <= X (`cfg_ae_ofs`). `wr_afull_n`=0 when N >= `DEPTH`-Y (`cfg_af_ofs`). `wr_room`=0 when N = `DEPTH`. Write-side flags reflect a write on that write's edge. Read-side flags reflect a read on that read's edge.
- R8: `cfg_fwft` (1 = fall-through, 0 = standard), `cfg_ae_ofs` and `cfg_af_ofs` are sampled only while reset is in force. Changing them afterwards has no effect.
- R9: After reset, `rd_avail`=0, `rd_aempty_n`=0, `wr_room`=1, `wr_afull_n`=1 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_fwft | input | 1 | Read mode captured during reset: 1 fall-through, 0 standard |
| cfg_ae_ofs | input | AW (4) | Almost-empty offset X, captured during reset |
| cfg_af_ofs | input | AW (4) | Almost-full offset Y, captured during reset |
| wr_en | input | 1 | Write enable |
| wr_mbox | input | 1 | Write qualifier; high diverts the write away from the queue |
| wr_data | input | DW (16) | Write data |
| wr_room | output | 1 | High while there is space (full flag or input-ready) |
| wr_afull_n | output | 1 | Low when the queue is nearly full |
| rd_cs_n | input | 1 | Read select, active low |
| rd_en | input | 1 | Read enable |
| rd_mbox | input | 1 | Read qualifier; high diverts the read away from the queue |
| rd_data | output | DW (16) | Output register |
| rd_avail | output | 1 | Not-empty flag (standard) or output-ready flag (fall-through) |
| rd_aempty_n | output | 1 | Low when few words remain in memory |

## Verification
The bench drives inputs, and samples, a quarter period after each rising edge. Every result is therefore read at the first sample that follows the edge on which the design is due to update it.

- Write-side flags (`wr_room`, `wr_afull_n`) change on the write edge itself.
- The fall-through load and the standard not-empty flag arrive after the second edge following a write. The bench checks that they are still absent after the first edge.
- A read changes `rd_data`, `rd_avail` and `rd_aempty_n` on the read edge.
- A read only reaches the write-side flags two edges later, so the fill checks start after the first pointer copy has settled.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  typedef enum logic {
    RD_STANDARD = 1'b0,
    RD_FALLTHRU = 1'b1
  } rd_mode_e;

endpackage

// File: rtl/dmf_rst_sync.sv
module dmf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/dmf_store.sv
module dmf_store #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells_q[waddr] <= wdata;
    end
  end

  assign rdata = cells_q[raddr];

endmodule

// File: rtl/dmf_wr_side.sv
module dmf_wr_side #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] af_ofs_i,
  input  logic          wr_req,
  input  logic [AW:0]   rptr_i,
  output logic [AW:0]   wptr_o,
  output logic          wr_fire,
  output logic          room_o,
  output logic          afull_n_o
);

  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [AW-1:0] af_ofs_q;
  logic [PW-1:0] wptr_q, wptr_d;
  logic [PW-1:0] rsync_q;
  logic [PW-1:0] used_d;
  logic          room_q, room_d;
  logic          afull_n_q, afull_n_d;

  // offset capture while reset is in force
  always_ff @(posedge clk) begin
    if (cfg_load) begin
      af_ofs_q <= af_ofs_i;
    end
  end

  always_comb begin
    wr_fire   = wr_req && room_q;
    wptr_d    = wptr_q + {{AW{1'b0}}, wr_fire};
    used_d    = wptr_d - rsync_q;
    room_d    = (used_d != FULL_CNT);
    afull_n_d = (used_d < (FULL_CNT - {1'b0, af_ofs_q}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      rsync_q   <= '0;
      room_q    <= 1'b1;
      afull_n_q <= 1'b1;
    end else begin
      wptr_q    <= wptr_d;
      rsync_q   <= rptr_i;
      room_q    <= room_d;
      afull_n_q <= afull_n_d;
    end
  end

  assign wptr_o    = wptr_q;
  assign room_o    = room_q;
  assign afull_n_o = afull_n_q;

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> ((wptr_q - rsync_q) < FULL_CNT));

  p_full_in_afull_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !room_q |-> !afull_n_q);

  p_idle_write_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> $stable(wptr_q));

endmodule

// File: rtl/dmf_rd_side.sv
module dmf_rd_side
  import dmf_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          fwft_i,
  input  logic [AW-1:0] ae_ofs_i,
  input  logic [AW:0]   wptr_i,
  input  logic          rd_req,
  input  logic [DW-1:0] mem_i,
  output logic [AW:0]   rptr_o,
  output logic [DW-1:0] data_o,
  output logic          avail_o,
  output logic          aempty_n_o
);

  localparam int PW = AW + 1;

  rd_mode_e      mode_q;
  logic [AW-1:0] ae_ofs_q;
  logic [PW-1:0] wsync_q;
  logic [PW-1:0] rptr_q, rptr_d;
  logic [PW-1:0] words_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          orl_q, orl_d;
  logic          nempty_q, nempty_d;
  logic          aempty_n_q, aempty_n_d;
  logic          fwft;
  logic          avail;
  logic          rd_fire;
  logic          mem_has;
  logic          shift;

  // mode and offset capture while reset is in force
  always_ff @(posedge clk) begin
    if (cfg_load) begin
      mode_q   <= rd_mode_e'(fwft_i);
      ae_ofs_q <= ae_ofs_i;
    end
  end

  always_comb begin
    fwft    = (mode_q == RD_FALLTHRU);
    avail   = fwft ? orl_q : nempty_q;
    rd_fire = rd_req && avail;
    mem_has = (wsync_q != rptr_q);
    shift   = mem_has && (fwft ? (!orl_q || rd_fire) : rd_fire);
    rptr_d  = rptr_q + {{AW{1'b0}}, shift};
    dout_d  = shift ? mem_i : dout_q;
    if (!fwft) begin
      orl_d = 1'b0;
    end else if (shift) begin
      orl_d = 1'b1;
    end else if (rd_fire) begin
      orl_d = 1'b0;
    end else begin
      orl_d = orl_q;
    end
    words_d    = wsync_q - rptr_d;
    nempty_d   = (words_d != '0);
    aempty_n_d = (words_d > {1'b0, ae_ofs_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsync_q    <= '0;
      rptr_q     <= '0;
      dout_q     <= '0;
      orl_q      <= 1'b0;
      nempty_q   <= 1'b0;
      aempty_n_q <= 1'b0;
    end else begin
      wsync_q    <= wptr_i;
      rptr_q     <= rptr_d;
      dout_q     <= dout_d;
      orl_q      <= orl_d;
      nempty_q   <= nempty_d;
      aempty_n_q <= aempty_n_d;
    end
  end

  assign rptr_o     = rptr_q;
  assign data_o     = dout_q;
  assign avail_o    = avail;
  assign aempty_n_o = aempty_n_q;

  p_autoload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && !orl_q && mem_has) |=> orl_q);

  p_ready_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && orl_q && !rd_req) |=> (orl_q && $stable(dout_q)));

  p_std_no_read_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && !rd_req) |=> $stable(dout_q));

  p_std_empty_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && !nempty_q) |-> !aempty_n_q);

  p_read_advances_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && rd_fire) |=> (rptr_q == $past(rptr_q) + 1'b1));

endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_fwft,
  input  logic [AW-1:0] cfg_ae_ofs,
  input  logic [AW-1:0] cfg_af_ofs,
  input  logic          wr_en,
  input  logic          wr_mbox,
  input  logic [DW-1:0] wr_data,
  output logic          wr_room,
  output logic          wr_afull_n,
  input  logic          rd_cs_n,
  input  logic          rd_en,
  input  logic          rd_mbox,
  output logic [DW-1:0] rd_data,
  output logic          rd_avail,
  output logic          rd_aempty_n
);

  localparam int PW = AW + 1;

  logic          srst_n;
  logic          cfg_load;
  logic          wr_req;
  logic          rd_req;
  logic          wr_fire;
  logic [PW-1:0] wptr;
  logic [PW-1:0] rptr;
  logic [DW-1:0] mem_rdata;

  assign cfg_load = !srst_n;
  assign wr_req   = wr_en && !wr_mbox;
  assign rd_req   = !rd_cs_n && rd_en && !rd_mbox;

  dmf_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dmf_store #(.DW(DW), .AW(AW)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wptr[AW-1:0]),
    .wdata (wr_data),
    .raddr (rptr[AW-1:0]),
    .rdata (mem_rdata)
  );

  dmf_wr_side #(.AW(AW)) u_wr (
    .clk       (clk),
    .rst_n     (srst_n),
    .cfg_load  (cfg_load),
    .af_ofs_i  (cfg_af_ofs),
    .wr_req    (wr_req),
    .rptr_i    (rptr),
    .wptr_o    (wptr),
    .wr_fire   (wr_fire),
    .room_o    (wr_room),
    .afull_n_o (wr_afull_n)
  );

  dmf_rd_side #(.DW(DW), .AW(AW)) u_rd (
    .clk        (clk),
    .rst_n      (srst_n),
    .cfg_load   (cfg_load),
    .fwft_i     (cfg_fwft),
    .ae_ofs_i   (cfg_ae_ofs),
    .wptr_i     (wptr),
    .rd_req     (rd_req),
    .mem_i      (mem_rdata),
    .rptr_o     (rptr),
    .data_o     (rd_data),
    .avail_o    (rd_avail),
    .aempty_n_o (rd_aempty_n)
  );

endmodule

// File: tb/tb_dmf_fifo.sv
module tb_dmf_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic          we;
    logic          wmb;
    logic [15:0]   wd;
    logic          cs_n;
    logic          re;
    logic          rmb;
    logic          ev;
    logic [15:0]   ed;
  } vec_t;

  // fall-through walk: inputs before edge i, expectations after edge i
  localparam vec_t VEC [20] = '{
    '{1'b1, 1'b0, 16'hA001, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA001},
    '{1'b1, 1'b0, 16'hB002, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA001},
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA001},
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA001},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'hB002},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'hB002},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'hB002},
    '{1'b1, 1'b0, 16'hC003, 1'b0, 1'b1, 1'b0, 1'b0, 16'hB002},
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'hB002},
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'hC003},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'hC003},
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 16'hC003},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 16'hC003},
    '{1'b1, 1'b1, 16'hD004, 1'b1, 1'b0, 1'b0, 1'b1, 16'hC003},
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'hC003},
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'hC003},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'hC003},
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC003}
  };

  logic          clk;
  logic          rst_n;
  logic          cfg_fwft;
  logic [AW-1:0] cfg_ae_ofs;
  logic [AW-1:0] cfg_af_ofs;
  logic          wr_en;
  logic          wr_mbox;
  logic [DW-1:0] wr_data;
  logic          wr_room;
  logic          wr_afull_n;
  logic          rd_cs_n;
  logic          rd_en;
  logic          rd_mbox;
  logic [DW-1:0] rd_data;
  logic          rd_avail;
  logic          rd_aempty_n;

  int checks;
  int fails;
  bit done;

  dmf_fifo #(.DW(DW), .AW(AW)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fwft    (cfg_fwft),
    .cfg_ae_ofs  (cfg_ae_ofs),
    .cfg_af_ofs  (cfg_af_ofs),
    .wr_en       (wr_en),
    .wr_mbox     (wr_mbox),
    .wr_data     (wr_data),
    .wr_room     (wr_room),
    .wr_afull_n  (wr_afull_n),
    .rd_cs_n     (rd_cs_n),
    .rd_en       (rd_en),
    .rd_mbox     (rd_mbox),
    .rd_data     (rd_data),
    .rd_avail    (rd_avail),
    .rd_aempty_n (rd_aempty_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD / 4);
  endtask

  task automatic idle_inputs();
    wr_en   = 1'b0;
    wr_mbox = 1'b0;
    wr_data = '0;
    rd_cs_n = 1'b1;
    rd_en   = 1'b0;
    rd_mbox = 1'b0;
  endtask

  task automatic do_reset(input logic fwft, input logic [AW-1:0] x, input logic [AW-1:0] y);
    idle_inputs();
    rst_n      = 1'b0;
    cfg_fwft   = fwft;
    cfg_ae_ofs = x;
    cfg_af_ofs = y;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic put(input logic [DW-1:0] d);
    idle_inputs();
    wr_en   = 1'b1;
    wr_data = d;
    tick();
    idle_inputs();
  endtask

  task automatic take();
    idle_inputs();
    rd_cs_n = 1'b0;
    rd_en   = 1'b1;
    tick();
    idle_inputs();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;

    // R9 reset state, fall-through, X=2 Y=3
    do_reset(1'b1, 4'd2, 4'd3);
    chk("R9", "rd_avail", 32'(rd_avail), 32'd0);
    chk("R9", "rd_aempty_n", 32'(rd_aempty_n), 32'd0);
    chk("R9", "wr_room", 32'(wr_room), 32'd1);
    chk("R9", "wr_afull_n", 32'(wr_afull_n), 32'd1);
    chk("R9", "rd_data", 32'(rd_data), 32'd0);

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < 20; i++) begin
      wr_en   = VEC[i].we;
      wr_mbox = VEC[i].wmb;
      wr_data = VEC[i].wd;
      rd_cs_n = VEC[i].cs_n;
      rd_en   = VEC[i].re;
      rd_mbox = VEC[i].rmb;
      tick();
      chk("R1/R2/R3/R4", $sformatf("row %0d rd_avail", i), 32'(rd_avail), 32'(VEC[i].ev));
      chk("R1/R2/R3/R4", $sformatf("row %0d rd_data", i), 32'(rd_data), 32'(VEC[i].ed));
    end
    idle_inputs();

    // R6 R7: fall-through capacity DEPTH+1, afull band with Y=3
    do_reset(1'b1, 4'd2, 4'd3);
    for (int n = 1; n <= DEPTH + 1; n++) begin
      put(16'h1000 + 16'(n));
      if (n >= 5) begin
        chk("R6", $sformatf("room after %0d writes", n), 32'(wr_room), 32'(n - 1 < DEPTH));
        chk("R7", $sformatf("afull_n after %0d writes", n), 32'(wr_afull_n),
            32'(n - 1 < DEPTH - 3));
      end
    end
    put(16'hDEAD);  // R2: refused while wr_room is low
    repeat (2) tick();
    chk("R7", "aempty_n when full", 32'(rd_aempty_n), 32'd1);
    chk("R4", "head word", 32'(rd_data), 32'h1001);
    for (int j = 1; j <= DEPTH + 1; j++) begin
      take();
      if (j <= DEPTH) begin
        chk("R4", $sformatf("order after read %0d", j), 32'(rd_data), 32'(16'h1000 + 16'(j + 1)));
        chk("R7", $sformatf("aempty_n after read %0d", j), 32'(rd_aempty_n),
            32'((DEPTH - j) > 2));
      end else begin
        chk("R6", "avail after draining", 32'(rd_avail), 32'd0);
      end
    end
    repeat (3) tick();
    chk("R2", "refused word absent", 32'(rd_avail), 32'd0);

    // R6: one word in output register is not counted
    put(16'hABCD);
    repeat (2) tick();
    chk("R6", "single word avail", 32'(rd_avail), 32'd1);
    chk("R6", "single word data", 32'(rd_data), 32'hABCD);
    chk("R6", "single word aempty_n", 32'(rd_aempty_n), 32'd0);

    // standard mode, X=1 Y=2; inputs changed after reset (R8)
    do_reset(1'b0, 4'd1, 4'd2);
    cfg_fwft   = 1'b1;
    cfg_ae_ofs = 4'd7;
    cfg_af_ofs = 4'd7;
    chk("R9", "std reset avail", 32'(rd_avail), 32'd0);
    put(16'h0A01);
    chk("R5", "avail after write edge", 32'(rd_avail), 32'd0);
    tick();
    chk("R5", "avail after first edge", 32'(rd_avail), 32'd0);
    tick();
    chk("R5", "avail after second edge", 32'(rd_avail), 32'd1);
    chk("R5", "no unrequested load", 32'(rd_data), 32'd0);
    put(16'h0A02);
    repeat (2) tick();
    chk("R8", "aempty_n uses reset X", 32'(rd_aempty_n), 32'd1);
    take();
    chk("R5", "first read data", 32'(rd_data), 32'h0A01);
    chk("R7", "aempty_n at one word", 32'(rd_aempty_n), 32'd0);
    chk("R5", "avail with one left", 32'(rd_avail), 32'd1);
    take();
    chk("R5", "second read data", 32'(rd_data), 32'h0A02);
    chk("R5", "avail after last", 32'(rd_avail), 32'd0);
    take();
    chk("R1", "read with avail low ignored", 32'(rd_data), 32'h0A02);

    // R7 R8: standard fill with Y=2
    for (int n = 1; n <= DEPTH; n++) begin
      put(16'h2000 + 16'(n));
      chk("R7", $sformatf("std room after %0d", n), 32'(wr_room), 32'(n < DEPTH));
      chk("R8", $sformatf("std afull_n after %0d", n), 32'(wr_afull_n), 32'(n < DEPTH - 2));
    end
    put(16'hBEEF);
    repeat (2) tick();
    take();
    chk("R8", "still standard mode order", 32'(rd_data), 32'h2001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule